// File: doc/BRIEF.md
# Tiny Harvard RISC Core

A small 32-bit processor with a private instruction store, a private data store and sixteen general registers. It executes a seven-instruction set. Nothing in it is cached implicitly: a pulse on `start` makes the core copy a full image of program words and data words from external memory into its local stores. It then runs from program address 0 until an ending instruction, writes the whole local data store back out, and raises `finish`.

Each instruction passes through five one-cycle steps: fetch, decode, execute, memory and writeback. An instruction is therefore complete before the next one is fetched, so no hazards can arise. The external memory model has a read latency of one cycle: a word requested in one cycle is returned in the next.

Top module: `tiny_harvard_core`

## Requirements
- R1: An instruction word carries its opcode in bits [2:0]: 0 FINISH, 1 WRITE_IMMEDIATE, 2 LOAD, 3 STORE, 4 BEQ, 5 BNE, 6 ADD. Bits [6:3] hold the destination (or the data register of LOAD/STORE, or the first compared register of a branch). Bits [10:7] hold the second register (LOAD/STORE address register, branch second operand, ADD first source). Bits [14:11] hold the ADD second source. Bits [24:15] hold the branch target.
- R2: After `start` is sampled high while idle or finished, the core reads instruction words at external addresses 0 to IMEM_WORDS-1 in ascending order, one per cycle. It then reads data words 0 to DMEM_WORDS-1 in the same way, and loads both local stores from the returned words.
- R3: Execution starts at address 0. Every instruction takes 5 cycles, except the ending one, which takes 3. `finish` rises exactly 1 + (IMEM_WORDS+1) + (DMEM_WORDS+1) + 5*(N-1) + 3 + DMEM_WORDS clock edges after the edge that samples `start`, where N is the number of instructions executed including the ending one.
- R4: WRITE_IMMEDIATE writes bits [31:7], sign-extended to 32 bits, into the destination register.
- R5: ADD writes the sum of its two source registers, modulo 2^32.
- R6: LOAD reads the local data word addressed by the low log2(DMEM_WORDS) bits of the address register. STORE writes the data register to that word.
- R7: BEQ jumps to the target (taken modulo IMEM_WORDS) when its two registers are equal. BNE jumps when they differ. Otherwise the next address is the current one plus 1.
- R8: FINISH, and also the undefined opcode 7, stop execution. The stopping instruction changes no register and no data word.
- R9: After stopping, the core writes all DMEM_WORDS local data words to external addresses 0 upward, one per cycle. It then holds `finish` high until the next `start`.
- R10: Register 0 is an ordinary register that can be written and read like any other.
- R11: During and after reset, `finish` is low and the core makes no external read or write until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin fill, run and dump |
| finish | output | 1 | High once the dump is complete, until the next start |
| imem_ext_rd | output | 1 | External instruction read request |
| imem_ext_addr | output | log2(IMEM_WORDS) | External instruction read address |
| imem_ext_rdata | input | 32 | Instruction word, one cycle after the request |
| dmem_ext_rd | output | 1 | External data read request |
| dmem_ext_wr | output | 1 | External data write strobe |
| dmem_ext_addr | output | log2(DMEM_WORDS) | External data address for reads and writes |
| dmem_ext_wdata | output | 32 | Data word being dumped |
| dmem_ext_rdata | input | 32 | Data word, one cycle after the request |

## Verification
The bench builds the core with IMEM_WORDS and DMEM_WORDS both set to 64. This keeps every fill and dump short, so several complete runs fit in a few thousand cycles. The small data store also means a register address above 63 exercises the low-bit address rule. The bench uses random operand vectors, a loop that BNE closes, and a directed program that covers negative immediates, carry-out in ADD, both branch outcomes, register 0 and the undefined opcode. For every run it compares the exact finish time and the whole dumped image against values it computes itself.

// File: rtl/thc_pkg.sv
package thc_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_REGS  = 16;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int TARGET_W  = 10;

    typedef enum logic [2:0] {
        OP_FINISH = 3'd0,
        OP_WRIMM  = 3'd1,
        OP_LOAD   = 3'd2,
        OP_STORE  = 3'd3,
        OP_BEQ    = 3'd4,
        OP_BNE    = 3'd5,
        OP_ADD    = 3'd6,
        OP_RSVD   = 3'd7
    } opcode_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_FILL_I,
        PH_FILL_D,
        PH_FETCH,
        PH_DECODE,
        PH_EXEC,
        PH_MEM,
        PH_WB,
        PH_DUMP,
        PH_DONE
    } phase_e;

    typedef struct packed {
        opcode_e                op;
        logic [REG_IDX_W-1:0]   rd;
        logic [REG_IDX_W-1:0]   ra;
        logic [REG_IDX_W-1:0]   rb;
        logic [WORD_W-1:0]      imm;
        logic [TARGET_W-1:0]    target;
        logic                   writes_reg;
        logic                   is_branch;
        logic                   stops;
    } decoded_t;

endpackage

// File: rtl/thc_ram.sv
module thc_ram #(
    parameter int DEPTH  = 1024,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/thc_regfile.sv
module thc_regfile
    import thc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] widx,
    input  logic [WORD_W-1:0]    wdata,
    input  logic [REG_IDX_W-1:0] ra_idx,
    output logic [WORD_W-1:0]    ra_data,
    input  logic [REG_IDX_W-1:0] rb_idx,
    output logic [WORD_W-1:0]    rb_data
);

    logic [WORD_W-1:0] regs_q [NUM_REGS];
    logic [WORD_W-1:0] regs_d [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];

    // R10: every index, 0 included, keeps a written value
    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(widx)] == $past(wdata));

endmodule

// File: rtl/thc_decode.sv
module thc_decode
    import thc_pkg::*;
(
    input  logic [WORD_W-1:0] insn,
    output decoded_t          dec
);

    always_comb begin
        dec.op         = opcode_e'(insn[2:0]);
        dec.rd         = insn[6:3];
        dec.ra         = (dec.op == OP_ADD) ? insn[10:7]  : insn[6:3];
        dec.rb         = (dec.op == OP_ADD) ? insn[14:11] : insn[10:7];
        dec.imm        = {{7{insn[31]}}, insn[31:7]};
        dec.target     = insn[24:15];
        dec.writes_reg = (dec.op == OP_WRIMM) || (dec.op == OP_LOAD) || (dec.op == OP_ADD);
        dec.is_branch  = (dec.op == OP_BEQ) || (dec.op == OP_BNE);
        dec.stops      = (dec.op == OP_FINISH) || (dec.op == OP_RSVD);
    end

endmodule

// File: rtl/tiny_harvard_core.sv
module tiny_harvard_core
    import thc_pkg::*;
#(
    parameter int IMEM_WORDS = 1024,
    parameter int DMEM_WORDS = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          finish,
    output logic                          imem_ext_rd,
    output logic [$clog2(IMEM_WORDS)-1:0] imem_ext_addr,
    input  logic [31:0]                   imem_ext_rdata,
    output logic                          dmem_ext_rd,
    output logic                          dmem_ext_wr,
    output logic [$clog2(DMEM_WORDS)-1:0] dmem_ext_addr,
    output logic [31:0]                   dmem_ext_wdata,
    input  logic [31:0]                   dmem_ext_rdata
);

    localparam int IAW   = $clog2(IMEM_WORDS);
    localparam int DAW   = $clog2(DMEM_WORDS);
    localparam int CNT_W = ((IAW > DAW) ? IAW : DAW) + 1;
    localparam logic [CNT_W-1:0] I_END    = CNT_W'(IMEM_WORDS);
    localparam logic [CNT_W-1:0] D_END    = CNT_W'(DMEM_WORDS);
    localparam logic [CNT_W-1:0] D_LASTW  = CNT_W'(DMEM_WORDS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [IAW-1:0]      pc;
        logic [WORD_W-1:0]   ir;
        logic [WORD_W-1:0]   opa;
        logic [WORD_W-1:0]   opb;
        logic [WORD_W-1:0]   res;
        logic                taken;
    } core_state_t;

    core_state_t st_q, st_d;
    decoded_t    dec;

    logic              imem_we;
    logic [IAW-1:0]    imem_waddr;
    logic [WORD_W-1:0] imem_rdata;
    logic              dmem_we;
    logic [DAW-1:0]    dmem_waddr;
    logic [WORD_W-1:0] dmem_wdata;
    logic [DAW-1:0]    dmem_raddr;
    logic [WORD_W-1:0] dmem_rdata;
    logic              rf_we;
    logic [WORD_W-1:0] ra_data;
    logic [WORD_W-1:0] rb_data;

    thc_ram #(.DEPTH(IMEM_WORDS), .WIDTH(WORD_W), .ADDR_W(IAW)) imem_i (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_ext_rdata),
        .raddr (st_q.pc),
        .rdata (imem_rdata)
    );

    thc_ram #(.DEPTH(DMEM_WORDS), .WIDTH(WORD_W), .ADDR_W(DAW)) dmem_i (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (dmem_wdata),
        .raddr (dmem_raddr),
        .rdata (dmem_rdata)
    );

    thc_decode decode_i (
        .insn (st_q.ir),
        .dec  (dec)
    );

    thc_regfile regfile_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .widx    (dec.rd),
        .wdata   (st_q.res),
        .ra_idx  (dec.ra),
        .ra_data (ra_data),
        .rb_idx  (dec.rb),
        .rb_data (rb_data)
    );

    always_comb begin
        st_d           = st_q;
        imem_ext_rd    = 1'b0;
        imem_ext_addr  = IAW'(st_q.cnt);
        dmem_ext_rd    = 1'b0;
        dmem_ext_wr    = 1'b0;
        dmem_ext_addr  = DAW'(st_q.cnt);
        dmem_ext_wdata = dmem_rdata;
        imem_we        = 1'b0;
        imem_waddr     = IAW'(st_q.cnt - 1'b1);
        dmem_we        = 1'b0;
        dmem_waddr     = DAW'(st_q.cnt - 1'b1);
        dmem_wdata     = dmem_ext_rdata;
        dmem_raddr     = (st_q.phase == PH_DUMP) ? DAW'(st_q.cnt) : DAW'(st_q.opb);
        rf_we          = 1'b0;

        unique case (st_q.phase)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    st_d.phase = PH_FILL_I;
                    st_d.cnt   = '0;
                end
            end
            PH_FILL_I: begin
                imem_ext_rd = (st_q.cnt < I_END);
                imem_we     = (st_q.cnt != '0);
                if (st_q.cnt == I_END) begin
                    st_d.phase = PH_FILL_D;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_FILL_D: begin
                dmem_ext_rd = (st_q.cnt < D_END);
                dmem_we     = (st_q.cnt != '0);
                if (st_q.cnt == D_END) begin
                    st_d.phase = PH_FETCH;
                    st_d.cnt   = '0;
                    st_d.pc    = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_FETCH: begin
                st_d.ir    = imem_rdata;
                st_d.phase = PH_DECODE;
            end
            PH_DECODE: begin
                st_d.opa   = ra_data;
                st_d.opb   = rb_data;
                st_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                st_d.res   = (dec.op == OP_WRIMM) ? dec.imm : (st_q.opa + st_q.opb);
                st_d.taken = ((dec.op == OP_BEQ) && (st_q.opa == st_q.opb)) ||
                             ((dec.op == OP_BNE) && (st_q.opa != st_q.opb));
                if (dec.stops) begin
                    st_d.phase = PH_DUMP;
                    st_d.cnt   = '0;
                end else begin
                    st_d.phase = PH_MEM;
                end
            end
            PH_MEM: begin
                if (dec.op == OP_LOAD) begin
                    st_d.res = dmem_rdata;
                end
                if (dec.op == OP_STORE) begin
                    dmem_we    = 1'b1;
                    dmem_waddr = DAW'(st_q.opb);
                    dmem_wdata = st_q.opa;
                end
                st_d.phase = PH_WB;
            end
            PH_WB: begin
                rf_we      = dec.writes_reg;
                st_d.pc    = st_q.taken ? IAW'(dec.target) : (st_q.pc + 1'b1);
                st_d.phase = PH_FETCH;
            end
            PH_DUMP: begin
                dmem_ext_wr = 1'b1;
                if (st_q.cnt == D_LASTW) begin
                    st_d.phase = PH_DONE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign finish = (st_q.phase == PH_DONE);

    // R2: fill reads step through consecutive addresses
    assert_fill_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        imem_ext_rd && $past(imem_ext_rd) |-> imem_ext_addr == $past(imem_ext_addr) + 1'b1);

    // R7: a BNE with unequal operands redirects to its target
    assert_bne_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WB) && (dec.op == OP_BNE) && (st_q.opa != st_q.opb)
        |=> st_q.pc == $past(IAW'(dec.target)));

    // R8: a stopping opcode leads straight into the dump
    assert_stop_to_dump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EXEC) && ((st_q.ir[2:0] == 3'd0) || (st_q.ir[2:0] == 3'd7))
        |=> dmem_ext_wr && (dmem_ext_addr == '0));

    // R9: dump writes are consecutive and finish follows a dump write
    assert_dump_ascending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_ext_wr && $past(dmem_ext_wr) |-> dmem_ext_addr == $past(dmem_ext_addr) + 1'b1);

    assert_finish_after_dump_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(finish) |-> $past(dmem_ext_wr));

    assert_finish_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        finish && !start |=> finish);

    // R11: no external traffic while idle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE) |-> !imem_ext_rd && !dmem_ext_rd && !dmem_ext_wr && !finish);

endmodule

// File: tb/tiny_harvard_core_tb_top.sv
module tiny_harvard_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IW = 64;
    localparam int DW = 64;
    localparam int IAW = $clog2(IW);
    localparam int DAW = $clog2(DW);

    logic           clk;
    logic           rst_n;
    logic           start;
    logic           finish;
    logic           imem_ext_rd;
    logic [IAW-1:0] imem_ext_addr;
    logic [31:0]    imem_ext_rdata;
    logic           dmem_ext_rd;
    logic           dmem_ext_wr;
    logic [DAW-1:0] dmem_ext_addr;
    logic [31:0]    dmem_ext_wdata;
    logic [31:0]    dmem_ext_rdata;

    logic [31:0] ext_i  [IW];
    logic [31:0] ext_d  [DW];
    logic [31:0] dump_d [DW];
    logic [31:0] exp_d  [DW];

    logic clr;
    int   ird_n, ird_bad, drd_n, drd_bad, wr_n, wr_bad;
    int   n_checks, n_fail;

    tiny_harvard_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .finish         (finish),
        .imem_ext_rd    (imem_ext_rd),
        .imem_ext_addr  (imem_ext_addr),
        .imem_ext_rdata (imem_ext_rdata),
        .dmem_ext_rd    (dmem_ext_rd),
        .dmem_ext_wr    (dmem_ext_wr),
        .dmem_ext_addr  (dmem_ext_addr),
        .dmem_ext_wdata (dmem_ext_wdata),
        .dmem_ext_rdata (dmem_ext_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // external memories with one cycle read latency, plus traffic monitors
    always_ff @(posedge clk) begin
        if (imem_ext_rd) imem_ext_rdata <= ext_i[imem_ext_addr];
        if (dmem_ext_rd) dmem_ext_rdata <= ext_d[dmem_ext_addr];
        if (dmem_ext_wr) dump_d[dmem_ext_addr] <= dmem_ext_wdata;
        if (clr) begin
            ird_n <= 0; ird_bad <= 0; drd_n <= 0; drd_bad <= 0; wr_n <= 0; wr_bad <= 0;
        end else begin
            if (imem_ext_rd) begin
                ird_n <= ird_n + 1;
                if (int'(imem_ext_addr) != ird_n) ird_bad <= ird_bad + 1;
            end
            if (dmem_ext_rd) begin
                drd_n <= drd_n + 1;
                if (int'(dmem_ext_addr) != drd_n) drd_bad <= drd_bad + 1;
            end
            if (dmem_ext_wr) begin
                wr_n <= wr_n + 1;
                if (int'(dmem_ext_addr) != wr_n) wr_bad <= wr_bad + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // R1 encodings
    function automatic logic [31:0] enc_wi(input int d, input int imm);
        logic [31:0] v = imm;
        return {v[24:0], 4'(d), 3'd1};
    endfunction
    function automatic logic [31:0] enc_mem(input logic [2:0] op, input int r, input int a);
        return {21'd0, 4'(a), 4'(r), op};
    endfunction
    function automatic logic [31:0] enc_br(input logic [2:0] op, input int s0, input int s1, input int tgt);
        return {7'd0, 10'(tgt), 4'd0, 4'(s1), 4'(s0), op};
    endfunction
    function automatic logic [31:0] enc_add(input int d, input int s0, input int s1);
        return {17'd0, 4'(s1), 4'(s0), 4'(d), 3'd6};
    endfunction
    function automatic int run_edges(input int n_insn);
        return 1 + (IW + 1) + (DW + 1) + 5 * (n_insn - 1) + 3 + DW;
    endfunction

    task automatic run_and_check(input int n_insn, input string tag);
        int  edges = 0;
        bit  fin_after_start = 1'b1;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr   = 1'b0;
        start = 1'b1;
        do begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            start = 1'b0;
            if (edges == 1) fin_after_start = finish;
        end while (!finish && edges < 5000);
        // R9: finish drops once a new start is taken
        chk(!fin_after_start, {"R9 finish low after start ", tag}, 32'(fin_after_start), 32'd0);
        // R3: exact run length
        chk(edges == run_edges(n_insn), {"R3 edges ", tag}, 32'(edges), 32'(run_edges(n_insn)));
        // R2: fill order and count
        chk(ird_n == IW && ird_bad == 0, {"R2 instr fill ", tag}, 32'(ird_n), 32'(IW));
        chk(drd_n == DW && drd_bad == 0, {"R2 data fill ", tag}, 32'(drd_n), 32'(DW));
        // R9: dump covers every word in order
        chk(wr_n == DW && wr_bad == 0, {"R9 dump ", tag}, 32'(wr_n), 32'(DW));
        for (int i = 0; i < DW; i++) begin
            chk(dump_d[i] === exp_d[i], $sformatf("R6 word %0d %s", i, tag), dump_d[i], exp_d[i]);
        end
    endtask

    task automatic load_vadd(input int n);
        for (int i = 0; i < IW; i++) ext_i[i] = 32'd0;
        ext_i[0]  = enc_wi(1, 0);
        ext_i[1]  = enc_wi(2, 8);
        ext_i[2]  = enc_wi(3, 16);
        ext_i[3]  = enc_wi(4, 1);
        ext_i[4]  = enc_wi(5, n);
        ext_i[5]  = enc_mem(3'd2, 7, 1);
        ext_i[6]  = enc_add(8, 1, 2);
        ext_i[7]  = enc_mem(3'd2, 9, 8);
        ext_i[8]  = enc_add(10, 7, 9);
        ext_i[9]  = enc_add(11, 1, 3);
        ext_i[10] = enc_mem(3'd3, 10, 11);
        ext_i[11] = enc_add(1, 1, 4);
        ext_i[12] = enc_br(3'd5, 1, 5, 5);
        ext_i[13] = 32'd0;
    endtask

    task automatic randomize_data();
        for (int i = 0; i < DW; i++) begin
            ext_d[i] = $urandom;
            exp_d[i] = ext_d[i];
        end
    endtask

    initial begin
        int unsigned seed_dummy;
        n_checks = 0;
        n_fail   = 0;
        clr      = 1'b1;
        start    = 1'b0;
        rst_n    = 1'b0;
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < IW; i++) ext_i[i] = 32'd0;
        for (int i = 0; i < DW; i++) ext_d[i] = 32'd0;

        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!finish && !imem_ext_rd && !dmem_ext_rd && !dmem_ext_wr, "R11 during reset",
            {28'd0, finish, imem_ext_rd, dmem_ext_rd, dmem_ext_wr}, 32'd0);
        rst_n = 1'b1;
        clr   = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!finish && !imem_ext_rd && !dmem_ext_rd && !dmem_ext_wr, "R11 idle after reset",
                {28'd0, finish, imem_ext_rd, dmem_ext_rd, dmem_ext_wr}, 32'd0);
        end

        // loop vector add, random operands (R1 R5 R6 R7 R8)
        for (int run = 0; run < 2; run++) begin
            load_vadd(8);
            randomize_data();
            if (run == 1) begin
                ext_d[0] = 32'hFFFF_FFFF;
                ext_d[8] = 32'h0000_0001;
                exp_d[0] = ext_d[0];
                exp_d[8] = ext_d[8];
            end
            for (int i = 0; i < 8; i++) exp_d[16 + i] = ext_d[i] + ext_d[8 + i];
            run_and_check(5 + 8 * 8 + 1, $sformatf("vadd%0d", run));
        end

        // R9: finish stays high while start is low
        repeat (5) @(negedge clk);
        chk(finish, "R9 finish held", 32'(finish), 32'd1);

        // directed program: R4 R5 R6 R7 R8 R10
        for (int i = 0; i < IW; i++) ext_i[i] = 32'd0;
        ext_i[0]  = enc_wi(0, -5);
        ext_i[1]  = enc_wi(1, 20);
        ext_i[2]  = enc_mem(3'd3, 0, 1);
        ext_i[3]  = enc_wi(2, -1);
        ext_i[4]  = enc_add(3, 2, 2);
        ext_i[5]  = enc_wi(4, DW + 21);
        ext_i[6]  = enc_mem(3'd3, 3, 4);
        ext_i[7]  = enc_br(3'd4, 2, 0, 9);
        ext_i[8]  = enc_wi(5, 7);
        ext_i[9]  = enc_br(3'd4, 2, 2, 11);
        ext_i[10] = enc_wi(5, 99);
        ext_i[11] = enc_wi(6, 22);
        ext_i[12] = enc_mem(3'd3, 5, 6);
        ext_i[13] = enc_wi(7, 20);
        ext_i[14] = enc_mem(3'd2, 8, 7);
        ext_i[15] = enc_wi(9, 23);
        ext_i[16] = enc_mem(3'd3, 8, 9);
        ext_i[17] = 32'h0000_0007;
        ext_i[18] = enc_wi(10, 24);
        ext_i[19] = enc_mem(3'd3, 10, 10);
        randomize_data();
        exp_d[20] = 32'hFFFF_FFFB;  // R4 R10: negative immediate via register 0
        exp_d[21] = 32'hFFFF_FFFE;  // R5 R6: wrapped sum, address DW+21 lands on 21
        exp_d[22] = 32'd7;          // R7: not-taken then taken BEQ
        exp_d[23] = 32'hFFFF_FFFB;  // R6: load of a stored word
        // R8: opcode 7 stops, so word 24 keeps its value
        run_and_check(17, "directed");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule